// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a predicate selector into a per-element enable mask for a vector pipeline of up to 64 elements. On a start request it samples a mode code, a 64-bit register value, an array of eight 4-bit condition fields, a starting field number, a bit selector and the active vector length. One clock later it presents the finished mask together with a one-cycle valid strobe.

The mask can come from one of several sources:
- all elements enabled;
- a single element picked by the register value (one bit set at that position);
- the register itself, or its bitwise complement;
- one chosen bit from each of a run of consecutive condition fields, taken as is or inverted.

Every bit at or past the vector length is cleared. A source mask and a destination mask for the same operation come from two instances, which may read different bits of the same condition fields.

Control is a two-state machine:
- `ST_IDLE` means no mask is being presented.
- `ST_EMIT` means the registered mask is valid this cycle.

Transitions:
- `ST_IDLE -> ST_EMIT` on start.
- `ST_EMIT -> ST_EMIT` on a back-to-back start.
- `ST_EMIT -> ST_IDLE` when start is low.

Top module: `pmask_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mask_valid` is 0 and `mask` is all zeros.
- R2: `mask_valid` is 1 in exactly the cycle after each cycle with `start` high. When `start` is low, `mask` holds its previous value.
- R3: Mode 0 sets every element below the vector length.
- R4: Mode 1 sets only element `reg_val`; a `reg_val` of 64 or more gives an all-zero mask.
- R5: Mode 2 gives element i the value of `reg_val` bit i.
- R6: Mode 3 gives element i the inverse of `reg_val` bit i.
- R7: Mode 4 gives element i the selected bit of condition field (`base_field` + i) mod 8. Field k occupies `cond_fields[4k+3:4k]`. The `cond_sel` codes are 0 = lt (field bit 3), 1 = gt (bit 2), 2 = eq (bit 1) and 3 = so (bit 0).
- R8: Mode 5 works as mode 4 but inverts the selected bit.
- R9: Mask bits at index `vec_len` and above are 0. A `vec_len` of 0 gives an all-zero mask, and any value above 64 acts as 64.
- R10: Modes 6 and 7 are reserved and give an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample the inputs and build a mask |
| mode | input | 3 | Predicate source selector |
| cond_sel | input | 2 | Bit picked from each condition field |
| reg_val | input | 64 | Integer register value |
| cond_fields | input | 32 | Eight packed 4-bit condition fields |
| base_field | input | 3 | First condition field, for element 0 |
| vec_len | input | 7 | Active vector length |
| mask_valid | output | 1 | Mask is valid this cycle |
| mask | output | 64 | Element predicate mask |

## Verification
The properties assume that `start`, `mode` and `vec_len` are stable around the sampling edge and are known (not X) after reset. The bench drives every input on the falling edge, so each value settles half a period before it is sampled. The one-hot and length properties also assume the default element count of 64. The stimulus includes every mode code, including both reserved ones, and vector lengths of 0, mid-range values and values above 64, so every guarded property is triggered.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
    localparam logic [2:0] PM_ALL    = 3'd0;
    localparam logic [2:0] PM_ONEHOT = 3'd1;
    localparam logic [2:0] PM_REG    = 3'd2;
    localparam logic [2:0] PM_NREG   = 3'd3;
    localparam logic [2:0] PM_CBIT   = 3'd4;
    localparam logic [2:0] PM_NCBIT  = 3'd5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pm_state_e;
endpackage

// File: rtl/pmask_int_src.sv
module pmask_int_src #(
    parameter int ELEMS = 64
) (
    input  logic [1:0]       sub_mode,
    input  logic [ELEMS-1:0] reg_val,
    output logic [ELEMS-1:0] int_mask
);
    localparam int SHW = $clog2(ELEMS);

    logic             in_range;
    logic [ELEMS-1:0] onehot;

    assign in_range = (reg_val[ELEMS-1:SHW] == '0);
    assign onehot   = in_range ? (ELEMS'(1) << reg_val[SHW-1:0]) : '0;

    always_comb begin
        unique case (sub_mode)
            2'd0:    int_mask = '1;
            2'd1:    int_mask = onehot;
            2'd2:    int_mask = reg_val;
            default: int_mask = ~reg_val;
        endcase
    end
endmodule

// File: rtl/pmask_cond_src.sv
module pmask_cond_src #(
    parameter int ELEMS   = 64,
    parameter int NFIELDS = 8,
    parameter int FIELD_W = 4
) (
    input  logic [NFIELDS*FIELD_W-1:0] cond_fields,
    input  logic [$clog2(NFIELDS)-1:0] base_field,
    input  logic [$clog2(FIELD_W)-1:0] cond_sel,
    input  logic                       invert,
    output logic [ELEMS-1:0]           cond_mask
);
    localparam int BW = $clog2(NFIELDS);
    localparam int SW = $clog2(FIELD_W);

    for (genvar i = 0; i < ELEMS; i++) begin : g_elem
        logic [BW-1:0]      idx;
        logic [FIELD_W-1:0] fld;
        assign idx          = base_field + BW'(i % NFIELDS);
        assign fld          = cond_fields[idx*FIELD_W +: FIELD_W];
        assign cond_mask[i] = fld[SW'(FIELD_W-1) - cond_sel] ^ invert;
    end
endmodule

// File: rtl/pmask_len_limit.sv
module pmask_len_limit #(
    parameter int ELEMS = 64,
    parameter int LEN_W = $clog2(ELEMS+1)
) (
    input  logic [LEN_W-1:0] vec_len,
    output logic [ELEMS-1:0] limit
);
    for (genvar i = 0; i < ELEMS; i++) begin : g_lim
        assign limit[i] = (LEN_W'(i) < vec_len);
    end
endmodule

// File: rtl/pmask_gen.sv
module pmask_gen
    import pmask_pkg::*;
#(
    parameter int ELEMS   = 64,
    parameter int NFIELDS = 8,
    parameter int FIELD_W = 4,
    parameter int BASE_W  = $clog2(NFIELDS),
    parameter int SEL_W   = $clog2(FIELD_W),
    parameter int LEN_W   = $clog2(ELEMS+1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 mode,
    input  logic [SEL_W-1:0]           cond_sel,
    input  logic [ELEMS-1:0]           reg_val,
    input  logic [NFIELDS*FIELD_W-1:0] cond_fields,
    input  logic [BASE_W-1:0]          base_field,
    input  logic [LEN_W-1:0]           vec_len,
    output logic                       mask_valid,
    output logic [ELEMS-1:0]           mask
);
    pm_state_e        state_q, state_d;
    logic [ELEMS-1:0] int_mask, cond_mask, limit, raw_mask;

    pmask_int_src #(.ELEMS(ELEMS)) u_int (
        .sub_mode (mode[1:0]),
        .reg_val  (reg_val),
        .int_mask (int_mask)
    );

    pmask_cond_src #(.ELEMS(ELEMS), .NFIELDS(NFIELDS), .FIELD_W(FIELD_W)) u_cond (
        .cond_fields (cond_fields),
        .base_field  (base_field),
        .cond_sel    (cond_sel),
        .invert      (mode[0]),
        .cond_mask   (cond_mask)
    );

    pmask_len_limit #(.ELEMS(ELEMS), .LEN_W(LEN_W)) u_lim (
        .vec_len (vec_len),
        .limit   (limit)
    );

    always_comb begin
        unique case (mode)
            PM_ALL, PM_ONEHOT, PM_REG, PM_NREG: raw_mask = int_mask;
            PM_CBIT, PM_NCBIT:                  raw_mask = cond_mask;
            default:                            raw_mask = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = start ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     mask <= '0;
        else if (start) mask <= raw_mask & limit;
    end

    assign mask_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/pmask_gen_chk.sv
module pmask_gen_chk #(
    parameter int ELEMS = 64,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       mode,
    input logic [LEN_W-1:0] vec_len,
    input logic             mask_valid,
    input logic [ELEMS-1:0] mask
);
    p_valid_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mask_valid);
    p_valid_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !mask_valid);
    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mask));
    p_all_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd0 && vec_len >= LEN_W'(ELEMS)) |=> (&mask));
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd1) |=> $onehot0(mask));
    p_len_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vec_len == '0) |=> (mask == '0));
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode >= 3'd6) |=> (mask == '0));
endmodule

bind pmask_gen pmask_gen_chk #(.ELEMS(ELEMS), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .vec_len    (vec_len),
    .mask_valid (mask_valid),
    .mask       (mask)
);

// File: tb/pmask_gen_tb.sv
module pmask_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  cond_sel = '0;
    logic [63:0] reg_val = '0;
    logic [31:0] cond_fields = '0;
    logic [2:0]  base_field = '0;
    logic [6:0]  vec_len = '0;
    logic        mask_valid;
    logic [63:0] mask;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic        exp_valid = 1'b0;
    logic [63:0] exp_mask = '0;
    string       exp_tag = "R1";
    string       in_tag = "R2";

    always #5 clk = ~clk;

    pmask_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .cond_sel(cond_sel), .reg_val(reg_val), .cond_fields(cond_fields),
        .base_field(base_field), .vec_len(vec_len),
        .mask_valid(mask_valid), .mask(mask)
    );

    function automatic logic [63:0] ref_mask(int md, int sel, logic [63:0] r,
                                             logic [31:0] cf, int base, int vl);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) begin
            bit b;
            case (md)
                0: b = 1;
                1: b = (r == 64'(i));
                2: b = r[i];
                3: b = !r[i];
                4, 5: begin
                    int f = (base + i) % 8;
                    b = cf[f*4 + (3 - sel)];
                    if (md == 5) b = !b;
                end
                default: b = 0;
            endcase
            if (i >= vl) b = 0;
            m[i] = b;
        end
        return m;
    endfunction

    // Reference model: advances on the rising edge, compared on the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_mask  <= '0;
            exp_tag   <= "R1";
        end else begin
            exp_valid <= start;
            exp_tag   <= start ? in_tag : "R2";
            if (start)
                exp_mask <= ref_mask(int'(mode), int'(cond_sel), reg_val, cond_fields,
                                     int'(base_field), int'(vec_len));
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (mask_valid !== exp_valid || mask !== exp_mask) begin
                fails++;
                $display("FAIL %s: valid=%0b mask=%h expected valid=%0b mask=%h",
                         exp_tag, mask_valid, mask, exp_valid, exp_mask);
            end
        end
    end

    task automatic go(input logic [2:0] md, input logic [1:0] sel, input logic [63:0] r,
                      input logic [31:0] cf, input logic [2:0] base, input logic [6:0] vl,
                      input string tag, input bit gap);
        @(negedge clk);
        mode = md; cond_sel = sel; reg_val = r; cond_fields = cf;
        base_field = base; vec_len = vl; in_tag = tag; start = 1'b1;
        if (gap) begin
            @(negedge clk);
            start = 1'b0;
            in_tag = "R2";
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 all ones, full and partial length
        go(3'd0, 2'd0, 64'h0, 32'h0, 3'd0, 7'd64, "R3", 1);
        go(3'd0, 2'd0, 64'h0, 32'h0, 3'd0, 7'd3, "R3", 1);
        // R4 one-hot
        go(3'd1, 2'd0, 64'd1, 32'h0, 3'd0, 7'd3, "R4", 1);
        go(3'd1, 2'd0, 64'd2, 32'h0, 3'd0, 7'd3, "R4", 1);
        go(3'd1, 2'd0, 64'd63, 32'h0, 3'd0, 7'd64, "R4", 1);
        go(3'd1, 2'd0, 64'd64, 32'h0, 3'd0, 7'd64, "R4", 1);
        go(3'd1, 2'd0, 64'h1_0000_0002, 32'h0, 3'd0, 7'd64, "R4", 1);
        go(3'd1, 2'd0, 64'd2, 32'h0, 3'd0, 7'd2, "R9", 1);
        // R5 / R6 integer and inverted
        go(3'd2, 2'd0, 64'hDEAD_BEEF_0123_4567, 32'h0, 3'd0, 7'd64, "R5", 1);
        go(3'd2, 2'd0, 64'b101, 32'h0, 3'd0, 7'd3, "R5", 1);
        go(3'd3, 2'd0, 64'b101, 32'h0, 3'd0, 7'd3, "R6", 1);
        go(3'd3, 2'd0, 64'hF0F0_0000_FFFF_0001, 32'h0, 3'd0, 7'd64, "R6", 1);
        // R7 condition bits: fields 4,6 eq=1; fields 5,7 lt=1
        go(3'd4, 2'd2, 64'h0, 32'h8282_0000, 3'd4, 7'd4, "R7", 1);
        go(3'd4, 2'd0, 64'h0, 32'h8282_0000, 3'd4, 7'd4, "R7", 1);
        go(3'd4, 2'd1, 64'h0, 32'h1234_5678, 3'd6, 7'd64, "R7", 1);
        go(3'd4, 2'd3, 64'h0, 32'hA5C3_0F96, 3'd7, 7'd20, "R7", 1);
        // R8 inverted condition (ne)
        go(3'd5, 2'd2, 64'h0, 32'h0000_0220, 3'd4, 7'd2, "R8", 1);
        go(3'd5, 2'd2, 64'h0, 32'h0002_0000, 3'd4, 7'd2, "R8", 1);
        // R9 length edge cases
        go(3'd0, 2'd0, 64'h0, 32'h0, 3'd0, 7'd0, "R9", 1);
        go(3'd0, 2'd0, 64'h0, 32'h0, 3'd0, 7'd100, "R9", 1);
        go(3'd0, 2'd0, 64'h0, 32'h0, 3'd0, 7'd63, "R9", 1);
        // R10 reserved modes
        go(3'd6, 2'd0, 64'hFFFF, 32'hFFFF_FFFF, 3'd0, 7'd64, "R10", 1);
        go(3'd7, 2'd0, 64'hFFFF, 32'hFFFF_FFFF, 3'd0, 7'd64, "R10", 1);
        // R2 back-to-back starts, then hold
        go(3'd2, 2'd0, 64'h55, 32'h0, 3'd0, 7'd64, "R2", 0);
        go(3'd3, 2'd0, 64'h55, 32'h0, 3'd0, 7'd64, "R2", 0);
        go(3'd1, 2'd0, 64'd5, 32'h0, 3'd0, 7'd64, "R2", 1);
        repeat (3) @(negedge clk);
        // mixed random patterns
        for (int k = 0; k < 300; k++) begin
            go(3'($urandom_range(0, 7)), 2'($urandom), {$urandom, $urandom}, 32'($urandom),
               3'($urandom), 7'($urandom_range(0, 70)), "R7", bit'($urandom));
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule